// File: doc/BRIEF.md
# Sleep Mode Clock-Gating Controller

This controller moves a small processor core between its running state and a low-power sleep state, then brings it back. A sleep request is honoured only while a separate sleep-enable input is high. When the request is taken, the controller captures a 3-bit mode code and a brown-out-off-in-sleep control bit. It then drops the clock enables that the mode calls for (CPU, flash, I/O) and leaves the ADC clock running. If the ADC is enabled, it also issues a single-cycle conversion start strobe as the core goes to sleep.

While asleep, the block watches a one-hot vector of wake-source types and discards any type that the captured mode does not allow. The first allowed source restores every clock enable and the brown-out enable. If the brown-out detector was switched off during sleep, the core stays held for a settling delay of about 60 microseconds, counted on the always-on clock. Otherwise it resumes in the next cycle. The clock gates, the brown-out detector and the ADC lie outside this block and are seen only as enables and status inputs.

Top module: `sleep_clkgate_ctrl`

## Requirements
- R1: After reset the block is running: cpu_ready, bod_en and all four clock enables are 1, and adc_start is 0.
- R2: While sleep_en is 0, a sleep_req has no effect: cpu_ready and all clock enables stay 1.
- R3: Mode code 000 (Idle) drives clk_en_cpu and clk_en_flash to 0 and keeps clk_en_io and clk_en_adc at 1, beginning the cycle after the accepted request. cpu_ready is 0 throughout sleep.
- R4: Mode code 001 (ADC noise reduction) drives clk_en_cpu, clk_en_flash and clk_en_io to 0 and keeps clk_en_adc at 1.
- R5: Mode codes 010 through 111 behave exactly like Idle.
- R6: In Idle, each of the 13 wake-source bits (bit 0 edge external interrupt, 1 level external interrupt, 2 pin change, 3 timer 0/1 overflow, 4 serial transmit complete, 5 ADC done, 6 external reset, 7 watchdog reset, 8 watchdog interrupt, 9 brown-out reset, 10 two-wire interrupt, 11 timer 2 interrupt, 12 nonvolatile-memory ready) ends sleep on its own.
- R7: In ADC noise reduction, only wake bits 1, 2 and 5 through 12 end sleep. Bits 0, 3 and 4 are ignored, and the block stays asleep.
- R8: adc_start pulses high for exactly one cycle, the first sleep cycle, if adc_enabled was 1 when the request was accepted. Otherwise it stays 0.
- R9: bod_en stays 1 through sleep when the brown-out-off control bit is 0. It is 0 for the whole sleep when the bit is 1, and it returns to 1 on wake-up.
- R10: When the brown-out detector was off in sleep, cpu_ready stays 0 for exactly SETTLE cycles after the waking edge, where SETTLE = ceil(60 * AON_CLK_KHZ / 1000), and all enables are 1 during that wait. When the detector stayed on, cpu_ready returns in the cycle after the waking edge.
- R11: The mode code and the brown-out control bit are captured on entry. Changing them during sleep has no effect until the next sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter sleep |
| sleep_en | input | 1 | Permits sleep requests |
| mode | input | 3 | Sleep mode code |
| bod_off_sleep | input | 1 | 1 switches the brown-out detector off during sleep |
| adc_enabled | input | 1 | ADC is enabled; a conversion starts on entry |
| wake_src | input | 13 | One-hot wake-source types |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| bod_en | output | 1 | Brown-out detector enable |
| adc_start | output | 1 | Conversion start strobe |
| cpu_ready | output | 1 | Core may execute |

## Verification
A wrong state register shows at the ports in the very next cycle. cpu_ready and the clock enables are decoded straight from the state and the captured mode, so a stuck or wrong state breaks the enable pattern at once. A wrong captured mode bit shows as a wrong clk_en_io level during sleep, or as a source that wakes the core when it should be ignored. A faulty settling counter shows only at wake-up, as cpu_ready rising too early or too late, so the wake-up wait is measured cycle by cycle against SETTLE.

// File: rtl/scg_pkg.sv
package scg_pkg;
  localparam int NUM_WAKE = 13;

  localparam int WK_EXT_EDGE  = 0;
  localparam int WK_EXT_LEVEL = 1;
  localparam int WK_PIN_CHG   = 2;
  localparam int WK_TMR_OVF   = 3;
  localparam int WK_SER_TXC   = 4;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2
  } scg_state_e;

  // Settling wait in always-on cycles: ceil(60 us * f), never below one.
  function automatic int settle_cycles(input int aon_khz);
    int c;
    c = (60 * aon_khz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  // Allowed wake types: every type in Idle; in ADC noise reduction the
  // edge interrupt, general timer overflow and transmit complete are dropped.
  function automatic logic [NUM_WAKE-1:0] wake_mask(input logic adcnr);
    logic [NUM_WAKE-1:0] m;
    m = '1;
    if (adcnr) begin
      m[WK_EXT_EDGE] = 1'b0;
      m[WK_TMR_OVF]  = 1'b0;
      m[WK_SER_TXC]  = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/scg_mode_decode.sv
module scg_mode_decode (
  input  logic [2:0] mode,
  output logic       is_adcnr
);
  // Only 001 selects noise reduction; every other code falls back to Idle.
  assign is_adcnr = (mode == 3'b001);
endmodule

// File: rtl/scg_wake_filter.sv
module scg_wake_filter #(
  parameter int W = scg_pkg::NUM_WAKE
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  output logic         hit
);
  assign hit = |(src & mask);
endmodule

// File: rtl/scg_settle_timer.sv
module scg_settle_timer #(
  parameter int CYCLES = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= LOAD_VAL;
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sleep_clkgate_ctrl.sv
module sleep_clkgate_ctrl #(
  parameter int AON_CLK_KHZ = 1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sleep_req,
  input  logic                         sleep_en,
  input  logic [2:0]                   mode,
  input  logic                         bod_off_sleep,
  input  logic                         adc_enabled,
  input  logic [scg_pkg::NUM_WAKE-1:0] wake_src,
  output logic                         clk_en_cpu,
  output logic                         clk_en_flash,
  output logic                         clk_en_io,
  output logic                         clk_en_adc,
  output logic                         bod_en,
  output logic                         adc_start,
  output logic                         cpu_ready
);
  import scg_pkg::*;

  localparam int SETTLE = settle_cycles(AON_CLK_KHZ);

  scg_state_e state_q, state_d;
  logic slp_adcnr_q, slp_bod_off_q, adc_start_q;
  logic mode_adcnr;
  logic in_run, in_sleep, settling;
  logic accept, wake_hit, settle_done, settle_load;
  logic [NUM_WAKE-1:0] live_mask;

  assign in_run   = (state_q == ST_RUN);
  assign in_sleep = (state_q == ST_SLEEP);
  assign settling = (state_q == ST_SETTLE);
  assign accept   = in_run && sleep_req && sleep_en;

  scg_mode_decode u_dec (
    .mode     (mode),
    .is_adcnr (mode_adcnr)
  );

  assign live_mask = wake_mask(slp_adcnr_q);

  scg_wake_filter #(.W(NUM_WAKE)) u_wake (
    .src  (wake_src),
    .mask (live_mask),
    .hit  (wake_hit)
  );

  assign settle_load = in_sleep && wake_hit && slp_bod_off_q;

  scg_settle_timer #(.CYCLES(SETTLE)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (settle_load),
    .run   (settling),
    .done  (settle_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (accept) state_d = ST_SLEEP;
      ST_SLEEP:  if (wake_hit) state_d = slp_bod_off_q ? ST_SETTLE : ST_RUN;
      ST_SETTLE: if (settle_done) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_RUN;
      slp_adcnr_q   <= 1'b0;
      slp_bod_off_q <= 1'b0;
      adc_start_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      adc_start_q <= accept && adc_enabled;
      if (accept) begin
        slp_adcnr_q   <= mode_adcnr;
        slp_bod_off_q <= bod_off_sleep;
      end
    end
  end

  assign clk_en_cpu   = !in_sleep;
  assign clk_en_flash = !in_sleep;
  assign clk_en_io    = !(in_sleep && slp_adcnr_q);
  assign clk_en_adc   = 1'b1;
  assign bod_en       = !(in_sleep && slp_bod_off_q);
  assign adc_start    = adc_start_q;
  assign cpu_ready    = in_run;
endmodule

// File: rtl/scg_checker.sv
module scg_checker (
  input logic clk,
  input logic rst_n,
  input logic sleep_req,
  input logic sleep_en,
  input logic clk_en_cpu,
  input logic clk_en_flash,
  input logic clk_en_io,
  input logic bod_en,
  input logic adc_start,
  input logic cpu_ready,
  input logic in_run,
  input logic in_sleep,
  input logic settling,
  input logic wake_hit,
  input logic slp_adcnr,
  input logic slp_bod_off
);
  p_ready_all_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> (clk_en_cpu && clk_en_flash && clk_en_io && bod_en));

  p_one_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({in_run, in_sleep, settling}));

  p_no_enable_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && sleep_req && !sleep_en) |=> cpu_ready);

  p_cpu_flash_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_cpu == clk_en_flash);

  p_idle_io_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && !slp_adcnr) |-> clk_en_io);

  p_stay_asleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && !wake_hit) |=> !cpu_ready);

  p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  p_start_in_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> in_sleep);

  p_bod_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && !slp_bod_off) |-> bod_en);

  p_settle_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> (!cpu_ready && clk_en_cpu && clk_en_io && bod_en));
endmodule

bind sleep_clkgate_ctrl scg_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep_req    (sleep_req),
  .sleep_en     (sleep_en),
  .clk_en_cpu   (clk_en_cpu),
  .clk_en_flash (clk_en_flash),
  .clk_en_io    (clk_en_io),
  .bod_en       (bod_en),
  .adc_start    (adc_start),
  .cpu_ready    (cpu_ready),
  .in_run       (in_run),
  .in_sleep     (in_sleep),
  .settling     (settling),
  .wake_hit     (wake_hit),
  .slp_adcnr    (slp_adcnr_q),
  .slp_bod_off  (slp_bod_off_q)
);

// File: tb/sleep_clkgate_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_clkgate_ctrl_tb;
  localparam int KHZ = 1000;
  localparam int NW  = 13;
  // Expected settle length restated from R10: ceil(60*KHZ/1000)
  localparam int EXP_SETTLE = (60 * KHZ + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, sleep_en = 1'b0, bod_off_sleep = 1'b0, adc_enabled = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [NW-1:0] wake_src = '0;
  logic clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, bod_en, adc_start, cpu_ready;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sleep_clkgate_ctrl #(.AON_CLK_KHZ(KHZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_en(sleep_en),
    .mode(mode), .bod_off_sleep(bod_off_sleep), .adc_enabled(adc_enabled),
    .wake_src(wake_src), .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash),
    .clk_en_io(clk_en_io), .clk_en_adc(clk_en_adc), .bod_en(bod_en),
    .adc_start(adc_start), .cpu_ready(cpu_ready)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pack_out();
    return {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, bod_en, adc_start, cpu_ready};
  endfunction

  // cpu,flash,io,adc,bod,start,ready
  localparam int RUN_PAT = 7'b1111101;

  task automatic enter(input logic [2:0] m, input logic bod, input logic adc);
    mode = m; bod_off_sleep = bod; adc_enabled = adc;
    sleep_en = 1'b1; sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
  endtask

  task automatic wake(input int bit_idx);
    wake_src = '0;
    wake_src[bit_idx] = 1'b1;
    tick();
    wake_src = '0;
  endtask

  task automatic t_reset();
    check("R1 reset outputs", pack_out(), RUN_PAT);
  endtask

  task automatic t_no_enable();
    sleep_en = 1'b0; sleep_req = 1'b1;
    tick(); tick();
    sleep_req = 1'b0;
    check("R2 request without enable", pack_out(), RUN_PAT);
  endtask

  task automatic t_idle();
    enter(3'b000, 1'b0, 1'b0);
    check("R3 idle enables", pack_out(), 7'b0011100);
    wake(3);
    check("R3 idle woke", cpu_ready, 1);
  endtask

  task automatic t_adcnr();
    enter(3'b001, 1'b0, 1'b0);
    check("R4 adcnr enables", pack_out(), 7'b0001100);
    wake(5);
    check("R4 adcnr woke", pack_out(), RUN_PAT);
  endtask

  task automatic t_other_codes();
    for (int m = 2; m < 8; m++) begin
      enter(3'(m), 1'b0, 1'b0);
      check($sformatf("R5 code %0d as idle", m), pack_out(), 7'b0011100);
      wake(4);
      check($sformatf("R5 code %0d idle wake", m), cpu_ready, 1);
    end
  endtask

  task automatic t_idle_wake_all();
    for (int b = 0; b < NW; b++) begin
      enter(3'b000, 1'b0, 1'b0);
      wake(b);
      check($sformatf("R6 idle wake bit %0d", b), cpu_ready, 1);
    end
  endtask

  task automatic t_adcnr_filter();
    for (int b = 0; b < NW; b++) begin
      bit allowed;
      allowed = !(b == 0 || b == 3 || b == 4);
      enter(3'b001, 1'b0, 1'b0);
      wake(b);
      check($sformatf("R7 adcnr bit %0d ready", b), cpu_ready, allowed ? 1 : 0);
      if (!allowed) begin
        check($sformatf("R7 adcnr bit %0d io held", b), clk_en_io, 0);
        wake(1);
        check("R7 adcnr later wake", cpu_ready, 1);
      end
    end
  endtask

  task automatic t_adc_start();
    enter(3'b000, 1'b0, 1'b1);
    check("R8 start pulse idle", adc_start, 1);
    tick();
    check("R8 start one cycle", adc_start, 0);
    wake(2);
    enter(3'b001, 1'b0, 1'b1);
    check("R8 start pulse adcnr", adc_start, 1);
    wake(5);
    check("R8 no pulse on wake", adc_start, 0);
    enter(3'b000, 1'b0, 1'b0);
    check("R8 no pulse adc off", adc_start, 0);
    wake(2);
  endtask

  task automatic t_bod_settle();
    int n;
    enter(3'b000, 1'b1, 1'b0);
    check("R9 bod off in sleep", bod_en, 0);
    tick();
    check("R9 bod still off", bod_en, 0);
    wake(8);
    check("R9 bod restored", bod_en, 1);
    check("R10 clocks back during settle", {clk_en_cpu, clk_en_flash, clk_en_io}, 3'b111);
    n = 0;
    while (!cpu_ready && n < 1000) begin
      if (!(clk_en_cpu && bod_en)) check("R10 enables in settle", 0, 1);
      tick();
      n++;
    end
    check("R10 settle length", n, EXP_SETTLE);
    enter(3'b000, 1'b0, 1'b0);
    check("R9 bod kept on", bod_en, 1);
    wake(8);
    check("R10 no settle when bod kept", cpu_ready, 1);
  endtask

  task automatic t_latched();
    enter(3'b001, 1'b0, 1'b0);
    mode = 3'b000; bod_off_sleep = 1'b1;
    tick();
    check("R11 mode held io", clk_en_io, 0);
    check("R11 bod bit held", bod_en, 1);
    wake(3);
    check("R11 mask held", cpu_ready, 0);
    wake(6);
    check("R11 wake without settle", cpu_ready, 1);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #23;
    rst_n = 1'b1;
    tick();
    t_reset();
    t_no_enable();
    t_idle();
    t_adcnr();
    t_other_codes();
    t_idle_wake_all();
    t_adcnr_filter();
    t_adc_start();
    t_bod_settle();
    t_latched();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule